// File: doc/BRIEF.md
# DMA Stream Width Packer

This block sits inside one DMA stream, between the side that reads items from a peripheral and the side that writes words to memory. It takes a valid/ready stream of source beats and produces a valid/ready stream of destination beats. Each side can be 8, 16 or 32 bits wide. When the source is narrower than the destination, several source items are packed into one output word. When the source is wider, one input word is split into several output beats. Both directions use little-endian lane order.

A transfer starts with a one-cycle `start` pulse. At that pulse the block latches the two width codes, the direct-mode select, the flow-control select, the burst length and the item count. The count is in source-width beats. In direct mode the block does no packing: the output uses the source width and the destination width code has no effect. When the peripheral controls the flow, the count is ignored and the transfer ends with the input beat that carries `in_last`. A stop request made partway through a transfer does not take effect until the current burst group has finished and no partly packed word remains.

The control is a four-state machine:
- `ST_IDLE`: the state after reset.
- `ST_FILL`: accepting input bytes into a four-lane byte buffer.
- `ST_DRAIN`: offering a destination word.
- `ST_DONE`: the transfer is finished.

The transitions are:
- IDLE→FILL and DONE→FILL on `start`.
- FILL→DRAIN when a full destination word, or the last remaining bytes, are held.
- FILL→DONE when the source is exhausted with the buffer empty, or when a pending stop meets a burst boundary with the buffer empty.
- DRAIN→DRAIN while another word is ready to go.
- DRAIN→FILL when more input is needed.
- DRAIN→DONE when the last byte has left the buffer.

Top module: `dma_width_packer`

## Requirements
- R1: Width codes map 0→8 bit, 1→16 bit, 2 or 3→32 bit. Only the low source-width bytes of `in_data` are used; its upper bytes have no effect on the output.
- R2: When packing, the first accepted item occupies the least-significant lanes of the output word, and each later item occupies the next higher lanes.
- R3: When unpacking, a wide input word leaves as destination beats starting with its lowest lanes.
- R4: With count N and no peripheral flow control, exactly N input beats are accepted, and `in_ready` stays low afterwards.
- R5: In direct mode, each input beat becomes one output beat of the source width, with zero upper lanes, whatever the destination code.
- R6: `out_valid` rises only when a full destination word is held. The single exception is the final word of a transfer, which carries the remaining bytes with zeros in the lanes above them. The number of output beats is ceil(N·src_bytes/dst_bytes).
- R7: With peripheral flow control, the latched count is ignored and the input beat flagged by `in_last` is the last one accepted.
- R8: `done` rises only after the source is exhausted and every buffered byte has been drained. It then stays high, with `in_ready` and `out_valid` low, until the next `start`.
- R9: A `stop_req` while busy ends the transfer only at a burst boundary with the buffer empty, so the number of output beats is a multiple of the burst length.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R11: After reset, `busy`, `done`, `in_ready` and `out_valid` are all low.
- R12: A start with count 0 and no flow control reaches `done` without moving any beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer and latch the configuration |
| src_size | input | 2 | Source width code |
| dst_size | input | 2 | Destination width code |
| direct_mode | input | 1 | Bypass packing; both sides use the source width |
| periph_flow | input | 1 | Peripheral ends the transfer with `in_last` |
| burst_len | input | BURST_W | Output beats per indivisible group (0 or 1 means none) |
| item_count | input | CNT_W | Number of source-width beats to move |
| stop_req | input | 1 | Request to end the transfer at the next burst boundary |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Source beat accepted |
| in_data | input | DATA_W | Source beat data |
| in_last | input | 1 | Final source beat (flow-control mode) |
| out_valid | output | 1 | Destination beat valid |
| out_ready | input | 1 | Destination beat taken |
| out_data | output | DATA_W | Destination beat data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |

## Verification
The bench targets the following corner cases:
- **Odd byte totals.** A 16-to-32 transfer with an odd count must flush a zero-padded residue. A design that waits for a full word hangs; a design that forgets to zero the upper lanes shows stale bytes.
- **Wide-to-narrow splitting.** A design that shifts the buffer the wrong way emits lanes in reverse order.
- **Direct mode with a wider destination code.** A design that obeys the destination code packs items it should pass through one by one.
- **Stop in the middle of a burst.** A design that honours the stop at once ends with a beat count that is not a multiple of the burst length.
- **Zero count and peripheral-ended transfers.** An off-by-one in the termination logic shows as an extra or a missing input beat.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } wpk_state_e;

    // width code to byte count: 0 -> 1, 1 -> 2, others -> 4
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/wpk_lane_buf.sv
module wpk_lane_buf #(
    parameter int LANES  = 4,
    parameter int FILL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 push,
    input  logic [FILL_W-1:0]    push_bytes,
    input  logic [8*LANES-1:0]   push_data,
    input  logic                 pop,
    input  logic [FILL_W-1:0]    pop_bytes,
    output logic [FILL_W-1:0]    fill_q,
    output logic [FILL_W-1:0]    fill_nx,
    output logic [8*LANES-1:0]   head_word
);
    localparam int WORD_W = 8 * LANES;

    logic [WORD_W-1:0] word_q, word_nx;
    logic [WORD_W-1:0] push_mask, head_mask;
    logic [FILL_W-1:0] pop_n;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            push_mask[8*i +: 8] = (FILL_W'(i) < push_bytes) ? 8'hFF : 8'h00;
            head_mask[8*i +: 8] = (FILL_W'(i) < pop_bytes)  ? 8'hFF : 8'h00;
        end
    end

    assign pop_n     = (pop_bytes < fill_q) ? pop_bytes : fill_q;
    assign head_word = word_q & head_mask;

    always_comb begin
        word_nx = word_q;
        fill_nx = fill_q;
        if (clear) begin
            word_nx = '0;
            fill_nx = '0;
        end else if (push) begin
            word_nx = word_q | ((push_data & push_mask) << (8 * fill_q));
            fill_nx = fill_q + push_bytes;
        end else if (pop) begin
            word_nx = word_q >> (8 * pop_n);
            fill_nx = fill_q - pop_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            fill_q <= '0;
        end else begin
            word_q <= word_nx;
            fill_q <= fill_nx;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(LANES)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ({1'b0, fill_q} + {1'b0, push_bytes} <= (FILL_W+1)'(LANES))); // R6

endmodule

// File: rtl/wpk_xfer_track.sv
module wpk_xfer_track #(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_count,
    input  logic               flow_ctl,
    input  logic               active,
    input  logic               in_fire,
    input  logic               in_last,
    input  logic               out_fire,
    input  logic [BURST_W-1:0] burst_len,
    input  logic               stop_req,
    output logic               src_end,
    output logic               src_end_nx,
    output logic [BURST_W-1:0] beat_q,
    output logic               stop_pend
);
    logic [CNT_W-1:0]   items_q, items_d;
    logic               last_q, last_d;
    logic [BURST_W-1:0] beat_d;
    logic               pend_d;

    always_comb begin
        items_d = items_q;
        last_d  = last_q;
        beat_d  = beat_q;
        pend_d  = stop_pend;
        if (load) begin
            items_d = load_count;
            last_d  = 1'b0;
            beat_d  = '0;
            pend_d  = 1'b0;
        end else begin
            if (in_fire && !flow_ctl && items_q != '0) items_d = items_q - 1'b1;
            if (in_fire && flow_ctl && in_last)        last_d  = 1'b1;
            if (out_fire) begin
                if (burst_len <= BURST_W'(1))            beat_d = '0;
                else if (beat_q + 1'b1 == burst_len)     beat_d = '0;
                else                                     beat_d = beat_q + 1'b1;
            end
            if (active && stop_req) pend_d = 1'b1;
        end
    end

    assign src_end    = flow_ctl ? last_q : (items_q == '0);
    assign src_end_nx = flow_ctl ? last_d : (items_d == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            items_q   <= '0;
            last_q    <= 1'b0;
            beat_q    <= '0;
            stop_pend <= 1'b0;
        end else begin
            items_q   <= items_d;
            last_q    <= last_d;
            beat_q    <= beat_d;
            stop_pend <= pend_d;
        end
    end

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> items_q <= $past(items_q)); // R4
    AST_FLOW_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_ctl && !load) |=> $stable(items_q)); // R7
    AST_BEAT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_len > BURST_W'(1)) |-> beat_q < burst_len); // R9

endmodule

// File: rtl/dma_width_packer.sv
module dma_width_packer
    import wpk_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         src_size,
    input  logic [1:0]         dst_size,
    input  logic               direct_mode,
    input  logic               periph_flow,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [CNT_W-1:0]   item_count,
    input  logic               stop_req,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               busy,
    output logic               done
);
    localparam int LANES  = DATA_W / 8;
    localparam int FILL_W = $clog2(LANES + 1);

    wpk_state_e state_q, state_d;

    logic [FILL_W-1:0]  sb_q, db_q;
    logic               dir_q, flow_q;
    logic [BURST_W-1:0] blen_q;

    logic               start_ok, in_fire, out_fire, stop_now;
    logic [FILL_W-1:0]  fill_q, fill_nx;
    logic               src_end, src_end_nx, stop_pend;
    logic [BURST_W-1:0] beat_q;
    logic [DATA_W-1:0]  head_word;

    assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign stop_now = stop_pend && (beat_q == '0) && (fill_q == '0);

    // configuration latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q   <= FILL_W'(1);
            db_q   <= FILL_W'(1);
            dir_q  <= 1'b0;
            flow_q <= 1'b0;
            blen_q <= '0;
        end else if (start_ok) begin
            sb_q   <= FILL_W'(size_bytes(src_size));
            db_q   <= direct_mode ? FILL_W'(size_bytes(src_size))
                                  : FILL_W'(size_bytes(dst_size));
            dir_q  <= direct_mode;
            flow_q <= periph_flow;
            blen_q <= burst_len;
        end
    end

    wpk_lane_buf #(.LANES(LANES), .FILL_W(FILL_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_ok),
        .push       (in_fire),
        .push_bytes (sb_q),
        .push_data  (in_data),
        .pop        (out_fire),
        .pop_bytes  (db_q),
        .fill_q     (fill_q),
        .fill_nx    (fill_nx),
        .head_word  (head_word)
    );

    wpk_xfer_track #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .load_count (item_count),
        .flow_ctl   (flow_q),
        .active     (busy),
        .in_fire    (in_fire),
        .in_last    (in_last),
        .out_fire   (out_fire),
        .burst_len  (blen_q),
        .stop_req   (stop_req),
        .src_end    (src_end),
        .src_end_nx (src_end_nx),
        .beat_q     (beat_q),
        .stop_pend  (stop_pend)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_ok) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (stop_now)
                    state_d = ST_DONE;
                else if (fill_nx >= db_q || (src_end_nx && fill_nx != '0))
                    state_d = ST_DRAIN;
                else if (src_end_nx)
                    state_d = ST_DONE;
            end
            ST_DRAIN: begin
                if (out_fire) begin
                    if (fill_nx >= db_q || (src_end && fill_nx != '0))
                        state_d = ST_DRAIN;
                    else if (src_end)
                        state_d = ST_DONE;
                    else
                        state_d = ST_FILL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FILL: begin
                busy     = 1'b1;
                in_ready = !src_end && !stop_now;
            end
            ST_DRAIN: begin
                busy      = 1'b1;
                out_valid = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign out_data = head_word;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (fill_q == '0)); // R8
    AST_DIRECT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dir_q) |-> ((out_data >> (8 * sb_q)) == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid)); // R11
    AST_STOP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && stop_pend) |-> (beat_q == '0)); // R9

endmodule

// File: tb/tb_dma_width_packer.sv
module tb_dma_width_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  src_size = '0, dst_size = '0;
    logic        direct_mode = 1'b0, periph_flow = 1'b0;
    logic [3:0]  burst_len = '0;
    logic [15:0] item_count = '0;
    logic        stop_req = 1'b0, in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, out_valid, busy, done;
    logic [31:0] out_data;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    dma_width_packer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_size(src_size), .dst_size(dst_size),
        .direct_mode(direct_mode), .periph_flow(periph_flow), .burst_len(burst_len),
        .item_count(item_count), .stop_req(stop_req), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .busy(busy), .done(done)
    );

    // behavioural reference: 0 idle, 1 fill, 2 drain, 3 done
    int          m_state = 0;
    byte         m_q[$];
    int          m_items, m_sb, m_db, m_bl;
    bit          m_last, m_pend, m_flow;
    int          m_beat;
    int          d_in_cnt = 0, d_out_cnt = 0;
    bit          acc, ofire, old_stop, end_n;
    int          pn;

    function automatic int nb(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic bit m_end();
        return m_flow ? m_last : (m_items == 0);
    endfunction

    function automatic bit m_stop_now();
        return m_pend && m_beat == 0 && m_q.size() == 0;
    endfunction

    function automatic bit m_in_ready();
        return m_state == 1 && !m_end() && !m_stop_now();
    endfunction

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        for (int i = 0; i < m_db && i < m_q.size(); i++) w[8*i +: 8] = m_q[i];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_q.delete(); m_pend = 0; m_beat = 0;
        end else begin
            acc      = in_valid && m_in_ready();
            ofire    = out_ready && (m_state == 2);
            old_stop = m_stop_now();
            if (in_valid && in_ready) d_in_cnt++;
            if (out_valid && out_ready) d_out_cnt++;
            case (m_state)
                0, 3: if (start) begin
                    m_state = 1; m_q.delete();
                    m_sb = nb(src_size);
                    m_db = direct_mode ? nb(src_size) : nb(dst_size);
                    m_flow = periph_flow; m_bl = burst_len; m_items = item_count;
                    m_last = 0; m_pend = 0; m_beat = 0;
                    d_in_cnt = 0; d_out_cnt = 0;
                end
                1: begin
                    if (old_stop) m_state = 3;
                    else begin
                        if (acc) begin
                            for (int i = 0; i < m_sb; i++) m_q.push_back(in_data[8*i +: 8]);
                            if (!m_flow) m_items--;
                            else if (in_last) m_last = 1;
                        end
                        end_n = m_end();
                        if (m_q.size() >= m_db || (end_n && m_q.size() > 0)) m_state = 2;
                        else if (end_n) m_state = 3;
                    end
                    if (stop_req) m_pend = 1;
                end
                2: begin
                    if (ofire) begin
                        pn = (m_db < m_q.size()) ? m_db : m_q.size();
                        for (int i = 0; i < pn; i++) void'(m_q.pop_front());
                        m_beat = (m_bl <= 1 || m_beat + 1 == m_bl) ? 0 : m_beat + 1;
                        if (m_q.size() >= m_db || (m_end() && m_q.size() > 0)) m_state = 2;
                        else if (m_end()) m_state = 3;
                        else m_state = 1;
                    end
                    if (stop_req) m_pend = 1;
                end
                default: ;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    bit          prev_v = 0, prev_r = 0;
    logic [31:0] prev_d = '0;

    task automatic cmp();
        check(in_ready === m_in_ready(), "R4 in_ready", 32'(in_ready), 32'(m_in_ready()));
        check(out_valid === (m_state == 2), "R6 out_valid", 32'(out_valid), 32'(m_state == 2));
        check(done === (m_state == 3), "R8 done", 32'(done), 32'(m_state == 3));
        check(busy === (m_state == 1 || m_state == 2), "R11 busy", 32'(busy), 32'(m_state == 1 || m_state == 2));
        if (m_state == 2)
            check(out_data === m_word(), "R1 R2 R3 lane data", out_data, m_word());
        if (prev_v && !prev_r)
            check(out_valid === 1'b1 && out_data === prev_d, "R10 stall hold", out_data, prev_d);
    endtask

    task automatic run(input int ss, input int ds, input bit dm, input bit pf, input int bl,
                       input int cnt, input int lastn, input int stop_at, input int exp_out);
        @(negedge clk);
        cmp();
        src_size = 2'(ss); dst_size = 2'(ds); direct_mode = dm; periph_flow = pf;
        burst_len = 4'(bl); item_count = 16'(cnt); start = 1'b1;
        in_valid = 0; out_ready = 0; stop_req = 0; in_last = 0; prev_v = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            cmp();
            start = 1'b0;
            if (m_state == 3) break;
            in_valid  = ($urandom % 4) != 0;
            in_data   = $urandom;
            in_last   = pf && (d_in_cnt == lastn - 1);
            out_ready = ($urandom % 3) != 0;
            stop_req  = (cyc == stop_at);
            prev_v = out_valid; prev_d = out_data; prev_r = out_ready;
        end
        in_valid = 0; out_ready = 0; stop_req = 0; in_last = 0; prev_v = 0;
        check(done === 1'b1, "R8 transfer finished", 32'(done), 32'd1);
        if (stop_at < 0) begin
            check(d_out_cnt == exp_out, "R6 output beat total", 32'(d_out_cnt), 32'(exp_out));
            if (pf) check(d_in_cnt == lastn, "R7 ends on last beat", 32'(d_in_cnt), 32'(lastn));
            else    check(d_in_cnt == cnt, "R4 input beat total", 32'(d_in_cnt), 32'(cnt));
            if (dm) check(d_out_cnt == d_in_cnt, "R5 one out per in", 32'(d_out_cnt), 32'(d_in_cnt));
            if (cnt == 0 && !pf) check(d_out_cnt == 0, "R12 zero count", 32'(d_out_cnt), 32'd0);
        end else begin
            check(d_out_cnt % bl == 0, "R9 burst boundary", 32'(d_out_cnt % bl), 32'd0);
            check(d_out_cnt * nb(ds) < cnt * nb(ss), "R9 stopped early",
                  32'(d_out_cnt), 32'(cnt));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp(); // R11 outputs quiet in reset
        rst_n = 1'b1;
        @(negedge clk);
        cmp();
        run(0, 2, 0, 0, 0, 8, 0, -1, 2);    // R2 pack 8->32
        run(1, 2, 0, 0, 0, 3, 0, -1, 2);    // R6 residue 16->32
        run(2, 0, 0, 0, 0, 2, 0, -1, 8);    // R3 unpack 32->8
        run(1, 0, 0, 0, 0, 3, 0, -1, 6);    // R3 16->8
        run(0, 1, 0, 0, 0, 5, 0, -1, 3);    // R6 8->16 residue
        run(1, 2, 1, 0, 0, 5, 0, -1, 5);    // R5 direct, dst code ignored
        run(0, 1, 0, 1, 0, 2, 5, -1, 3);    // R7 flow control, count ignored
        run(0, 3, 0, 0, 0, 0, 0, -1, 0);    // R12 zero count, code 3 = 32 bit
        run(0, 0, 0, 0, 4, 40, 0, 7, 0);    // R9 stop mid-burst
        run(2, 2, 0, 0, 2, 6, 0, -1, 6);    // R1 32->32 with burst
        run(2, 0, 0, 0, 4, 20, 0, 3, 0);    // R9 stop while unpacking
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule